// File: doc/BRIEF.md
# Non-destructive AND test unit

This unit forms the bitwise AND of two bytes and reports only status flags computed from that result. The AND value itself is never returned to a register and never written to a port. The caller's operands, including the accumulator and the register under test, are only read and come back unchanged.

Three operand pairings are selected by `mode`. The first is the accumulator with a selected register byte. The second is the accumulator with an immediate byte. The third is a byte read from an I/O port with an immediate byte.

The two register-side pairings finish in one clock. The I/O pairing first issues a read request. The request carries an address whose low byte is the port register and whose upper byte is zero. The unit keeps the request up until the responder marks the read data valid, and only then updates the flags and pulses `done`.

Top module: `nd_and_tester`

## Requirements
- R1: With `mode`=2'b00 and `start` high at a clock edge while no read is pending, `flags` holds the flags of `acc & reg_opnd` and `done` is high in the cycle after that edge.
- R2: With `mode`=2'b01, the same timing applies with the AND of `acc` and `imm`.
- R3: With `mode`=2'b10, `io_rd_req` rises in the cycle after the accepted `start`. It stays high until a cycle in which `io_rd_valid` is high. In the cycle after that cycle, `done` pulses, `io_rd_req` is low, and `flags` holds the flags of `io_rd_data & imm`.
- R4: While `io_rd_req` is high, `io_addr` holds `port_sel` as sampled at the accepted `start` in bits 7:0, with zeros in bits 15:8. It stays stable for the whole read.
- R5: The flag vector is laid out as follows. Bit 7 is the sign flag, a copy of result bit 7. Bit 6 is the zero flag, set when the result is 0. Bit 4 is the half-carry flag, always 1 after a test. Bit 2 is the parity flag, set when the result has an even number of ones. Bit 1 (subtract) and bit 0 (carry) are 0. Bits 5 and 3 are 0.
- R6: A `start` that arrives while a read is pending is ignored. It causes no `done`, no change to `flags`, and no change to `io_addr`.
- R7: `mode`=2'b11 is reserved. A `start` with that mode produces no `done`, no read request, and no change to `flags`.
- R8: After reset, `flags` is 8'h00, and `done` and `io_rd_req` are low.
- R9: In I/O mode the immediate is captured at the accepted `start`. Changes to `imm` while the read is pending do not affect the result.
- R10: `flags` changes only in cycles in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| start | input | 1 | Begin one test |
| mode | input | 2 | Operand pairing: 00 acc/reg, 01 acc/imm, 10 port/imm, 11 reserved |
| acc | input | 8 | Accumulator byte |
| reg_opnd | input | 8 | Selected register byte |
| imm | input | 8 | Immediate byte |
| port_sel | input | 8 | Port register supplying the low address byte |
| io_rd_req | output | 1 | I/O read request, held until data is valid |
| io_addr | output | 16 | I/O read address, upper byte zero |
| io_rd_data | input | 8 | I/O read data |
| io_rd_valid | input | 1 | Read data valid this cycle |
| flags | output | 8 | Status flag vector |
| done | output | 1 | One-cycle completion strobe |

## Verification
For the register and immediate pairings, `flags` and `done` are due one edge after the `start` edge. The bench drives inputs on falling edges and samples on the next falling edge. For the I/O pairing, the request and address are due one edge after `start`, and the flags and `done` are due one edge after the `io_rd_valid` edge. The bench checks the request on the falling edge after `start`, holds `io_rd_valid` off for a few cycles to confirm that nothing completes early, and then samples the result half a cycle after the valid edge. The ignored-`start` and reserved-mode cases are sampled on the cycle where a `done` would otherwise have appeared.

// File: rtl/ndat_pkg.sv
package ndat_pkg;
   typedef enum logic [1:0] {
      TM_REG = 2'b00,
      TM_IMM = 2'b01,
      TM_IO  = 2'b10,
      TM_RSV = 2'b11
   } tmode_e;

   localparam int FLG_W = 8;
   localparam int FLG_S = 7;
   localparam int FLG_Z = 6;
   localparam int FLG_H = 4;
   localparam int FLG_P = 2;
   localparam int FLG_N = 1;
   localparam int FLG_C = 0;
endpackage

// File: rtl/ndat_flagcalc.sv
module ndat_flagcalc
   import ndat_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit PARITY_TREE = 1'b1
) (
   input  logic [DATA_W-1:0] res,
   output logic [FLG_W-1:0]  flg
);
   logic par_odd;

   generate
      if (PARITY_TREE) begin : g_par_tree
         assign par_odd = ^res;
      end else begin : g_par_chain
         logic [DATA_W:0] chain;
         assign chain[0] = 1'b0;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign chain[i+1] = chain[i] ^ res[i];
         end
         assign par_odd = chain[DATA_W];
      end
   endgenerate

   always_comb begin
      flg        = '0;
      flg[FLG_S] = res[DATA_W-1];
      flg[FLG_Z] = (res == '0);
      flg[FLG_H] = 1'b1;
      flg[FLG_P] = ~par_odd;
      flg[FLG_N] = 1'b0;
      flg[FLG_C] = 1'b0;
   end
endmodule

// File: rtl/ndat_opsel.sv
module ndat_opsel
   import ndat_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [1:0]        mode,
   input  logic              io_phase,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] reg_opnd,
   input  logic [DATA_W-1:0] imm,
   input  logic [DATA_W-1:0] io_data,
   input  logic [DATA_W-1:0] io_imm,
   output logic [DATA_W-1:0] res
);
   logic [DATA_W-1:0] lhs, rhs;

   always_comb begin
      if (io_phase) begin
         lhs = io_data;
         rhs = io_imm;
      end else begin
         lhs = acc;
         rhs = (tmode_e'(mode) == TM_IMM) ? imm : reg_opnd;
      end
      res = lhs & rhs;
   end
endmodule

// File: rtl/ndat_ioseq.sv
module ndat_ioseq #(
   parameter int DATA_W = 8,
   parameter int PORT_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [PORT_W-1:0] port,
   input  logic [DATA_W-1:0] imm,
   input  logic              rd_valid,
   output logic              rd_req,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] imm_q,
   output logic              finish
);
   localparam int PAD_W = ADDR_W - PORT_W;

   logic [PORT_W-1:0] port_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_req <= 1'b0;
         port_q <= '0;
         imm_q  <= '0;
      end else if (launch) begin
         rd_req <= 1'b1;
         port_q <= port;
         imm_q  <= imm;
      end else if (finish) begin
         rd_req <= 1'b0;
      end
   end

   assign finish = rd_req & rd_valid;

   generate
      if (PAD_W > 0) begin : g_pad
         assign addr = {{PAD_W{1'b0}}, port_q};
      end else begin : g_nopad
         assign addr = port_q;
      end
   endgenerate
endmodule

// File: rtl/nd_and_tester.sv
module nd_and_tester
   import ndat_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int PORT_W      = 8,
   parameter int ADDR_W      = 16,
   parameter bit PARITY_TREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        mode,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] reg_opnd,
   input  logic [DATA_W-1:0] imm,
   input  logic [PORT_W-1:0] port_sel,
   output logic              io_rd_req,
   output logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_rd_data,
   input  logic              io_rd_valid,
   output logic [FLG_W-1:0]  flags,
   output logic              done
);
   generate
      if (ADDR_W < PORT_W) begin : g_bad_addr
         $error("ADDR_W must be at least PORT_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
   endgenerate

   logic              accept, launch_io, direct, finish, update;
   logic [DATA_W-1:0] io_imm_q, res;
   logic [FLG_W-1:0]  flg_next;

   assign accept    = start & ~io_rd_req;
   assign launch_io = accept & (tmode_e'(mode) == TM_IO);
   assign direct    = accept & ((tmode_e'(mode) == TM_REG) | (tmode_e'(mode) == TM_IMM));
   assign update    = direct | finish;

   ndat_ioseq #(
      .DATA_W (DATA_W),
      .PORT_W (PORT_W),
      .ADDR_W (ADDR_W)
   ) u_ioseq (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch_io),
      .port     (port_sel),
      .imm      (imm),
      .rd_valid (io_rd_valid),
      .rd_req   (io_rd_req),
      .addr     (io_addr),
      .imm_q    (io_imm_q),
      .finish   (finish)
   );

   ndat_opsel #(.DATA_W(DATA_W)) u_opsel (
      .mode     (mode),
      .io_phase (finish),
      .acc      (acc),
      .reg_opnd (reg_opnd),
      .imm      (imm),
      .io_data  (io_rd_data),
      .io_imm   (io_imm_q),
      .res      (res)
   );

   ndat_flagcalc #(
      .DATA_W      (DATA_W),
      .PARITY_TREE (PARITY_TREE)
   ) u_flagcalc (
      .res (res),
      .flg (flg_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
         done  <= 1'b0;
      end else begin
         done <= update;
         if (update) flags <= flg_next;
      end
   end
endmodule

// File: rtl/ndat_chk.sv
module ndat_chk
   import ndat_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PORT_W = 8,
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [1:0]        mode,
   input logic              io_rd_req,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_rd_valid,
   input logic [FLG_W-1:0]  flags,
   input logic              done
);
   // R1, R2: a direct-mode start completes on the next edge
   p_direct_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !io_rd_req && (mode == 2'b00 || mode == 2'b01)) |=> done);

   // R3: a valid read retires the request and completes
   p_io_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd_req && io_rd_valid) |=> (done && !io_rd_req));

   // R3, R4: the request and its address hold while no data is valid
   p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd_req && !io_rd_valid) |=> (io_rd_req && $stable(io_addr)));

   // R4: upper address bits are zero during a read
   p_addr_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
      io_rd_req |-> (io_addr[ADDR_W-1:PORT_W] == '0));

   // R5: fixed flag bits after every test
   p_fixed_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flags[FLG_H] && !flags[FLG_N] && !flags[FLG_C] && !flags[5] && !flags[3]));

   // R7: reserved mode starts nothing
   p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !io_rd_req && mode == 2'b11) |=> (!done && !io_rd_req));

   // R10: flags move only with done
   p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(flags));
endmodule

bind nd_and_tester ndat_chk #(
   .DATA_W (DATA_W),
   .PORT_W (PORT_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .mode        (mode),
   .io_rd_req   (io_rd_req),
   .io_addr     (io_addr),
   .io_rd_valid (io_rd_valid),
   .flags       (flags),
   .done        (done)
);

// File: tb/sim_nd_and_tester.sv
module sim_nd_and_tester;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;

   // fields: mode[41:40] acc[39:32] reg_or_port[31:24] imm[23:16] iodata[15:8] result[7:0]
   localparam logic [41:0] VECS [NVEC] = '{
      {2'b00, 8'hF0, 8'h0F, 8'h00, 8'h00, 8'h00},
      {2'b00, 8'hFF, 8'h81, 8'h00, 8'h00, 8'h81},
      {2'b01, 8'h3C, 8'h00, 8'h07, 8'h00, 8'h04},
      {2'b01, 8'hAA, 8'h00, 8'hAA, 8'h00, 8'hAA},
      {2'b10, 8'h00, 8'h3C, 8'hF0, 8'h5A, 8'h50},
      {2'b10, 8'hFF, 8'hA5, 8'h01, 8'hFE, 8'h00},
      {2'b00, 8'h7F, 8'h7E, 8'h00, 8'h00, 8'h7E},
      {2'b10, 8'h00, 8'hFF, 8'hFF, 8'h80, 8'h80}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [7:0]  acc = '0, reg_opnd = '0, imm = '0, port_sel = '0, io_rd_data = '0;
   logic        io_rd_valid = 1'b0;
   logic        io_rd_req, done;
   logic [15:0] io_addr;
   logic [7:0]  flags;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nd_and_tester u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .acc(acc),
      .reg_opnd(reg_opnd), .imm(imm), .port_sel(port_sel),
      .io_rd_req(io_rd_req), .io_addr(io_addr), .io_rd_data(io_rd_data),
      .io_rd_valid(io_rd_valid), .flags(flags), .done(done)
   );

   // R5 encoding, from the requirement text
   function automatic logic [7:0] want_flags(input logic [7:0] r);
      int ones = 0;
      for (int i = 0; i < 8; i++) ones += int'(r[i]);
      return {r[7], (r == 8'h00), 1'b0, 1'b1, 1'b0, ((ones % 2) == 0), 1'b0, 1'b0};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run_vec(input logic [41:0] v, input int idx);
      logic [7:0] exp_f;
      exp_f = want_flags(v[7:0]);
      mode = v[41:40]; acc = v[39:32]; reg_opnd = v[31:24];
      port_sel = v[31:24]; imm = v[23:16]; start = 1'b1;
      step();
      start = 1'b0;
      if (v[41:40] == 2'b10) begin
         check(io_rd_req == 1'b1, "R3 req raised", 32'(io_rd_req), 1);
         check(io_addr == {8'h00, v[31:24]}, "R4 address", 32'(io_addr), {24'h0, v[31:24]});
         imm = ~v[23:16]; // R9: capture at start
         step();
         check(done == 1'b0 && io_rd_req == 1'b1, "R3 wait", 32'({done, io_rd_req}), 1);
         io_rd_data = v[15:8]; io_rd_valid = 1'b1;
         step();
         io_rd_valid = 1'b0;
         check(done == 1'b1 && io_rd_req == 1'b0, "R3 complete", 32'({done, io_rd_req}), 2);
         check(flags == exp_f, $sformatf("R5 R9 io vec %0d", idx), 32'(flags), 32'(exp_f));
      end else begin
         check(done == 1'b1, $sformatf("R1 R2 done vec %0d", idx), 32'(done), 1);
         check(flags == exp_f, $sformatf("R1 R2 R5 flags vec %0d", idx), 32'(flags), 32'(exp_f));
      end
      step();
      check(done == 1'b0, "R10 done pulse", 32'(done), 0);
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R3 watchdog expired actual=hung expected=finished");
      summary();
   end

   initial begin
      logic [7:0] held;
      @(negedge clk); @(negedge clk);
      // R8 reset state
      check(flags == 8'h00 && done == 1'b0 && io_rd_req == 1'b0, "R8 reset",
            32'({flags, done, io_rd_req}), 0);
      rst_n = 1'b1;
      step();

      for (int k = 0; k < NVEC; k++) run_vec(VECS[k], k);

      // R1 back-to-back direct tests keep done high
      mode = 2'b00; acc = 8'h0F; reg_opnd = 8'h03; start = 1'b1;
      step();
      check(done && flags == want_flags(8'h03), "R1 first", 32'(flags), 32'(want_flags(8'h03)));
      acc = 8'h80; reg_opnd = 8'h80;
      step();
      start = 1'b0;
      check(done && flags == want_flags(8'h80), "R1 second", 32'(flags), 32'(want_flags(8'h80)));
      step();

      // R6 start during a pending read is ignored
      held = flags;
      mode = 2'b10; port_sel = 8'h12; imm = 8'h0F; start = 1'b1;
      step();
      mode = 2'b00; port_sel = 8'h99; acc = 8'hFF; reg_opnd = 8'h00;
      step();
      start = 1'b0;
      check(done == 1'b0 && flags == held, "R6 no done", 32'({done, flags}), 32'(held));
      check(io_addr == 16'h0012, "R6 R4 addr kept", 32'(io_addr), 32'h12);
      io_rd_data = 8'h3C; io_rd_valid = 1'b1;
      step();
      io_rd_valid = 1'b0;
      check(done && flags == want_flags(8'h0C), "R6 io result", 32'(flags), 32'(want_flags(8'h0C)));
      step();

      // R7 reserved mode
      held = flags;
      mode = 2'b11; acc = 8'h00; start = 1'b1;
      step();
      start = 1'b0;
      check(done == 1'b0 && io_rd_req == 1'b0 && flags == held, "R7 reserved",
            32'({done, io_rd_req, flags}), 32'(held));
      step();
      check(flags == held, "R10 flags held", 32'(flags), 32'(held));

      summary();
   end
endmodule